// File: doc/BRIEF.md
# Buffered Modulus Counter Channel

This block is the counting core of one timer channel. Its counter runs between 1 and a modulus held in an active register. Software never writes the active register directly. Writes land in a shadow register, and the shadow value is copied into the active register only at a cycle boundary. Because of this, a period that is already running always finishes with the modulus it started with.

The counter moves only on a tick. The tick comes from one of two sources: a prescaled tick supplied from outside, or a chosen edge of the channel's input pin. Two counting modes are available:

- Up mode wraps from the modulus back to 1.
- Up/down mode climbs to the modulus, falls back to 1, and climbs again. Its period is twice the modulus minus two ticks.

A sticky flag marks the chosen points of each cycle and stays set until it is cleared.

Top module: `bmc_channel`

## Requirements
- R1: After synchronous reset the count is 1, the active and shadow moduli both equal the parameter DEF_MOD (default 4), the direction is upward and the flag is 0.
- R2: With `ext_sel` = 0 only `pre_tick` advances the counter. With `ext_sel` = 1 only qualified edges of `pin_in` advance it, and `pre_tick` is ignored.
- R3: `edge_sel` picks the active pin edge: 2'b01 rising, 2'b10 falling, 2'b11 both, 2'b00 none. An edge is a change of `pin_in` between two consecutive clock samples. The first sample after reset is compared against a previous value of 0.
- R4: In up mode (`ud_mode` = 0) each tick adds 1 to the count. A tick taken while the count equals the active modulus sets the count to 1 instead, so the period is the modulus.
- R5: In up/down mode (`ud_mode` = 1) the count rises by 1 per tick until it equals the modulus. The next tick turns it downward, and it then falls by 1 per tick to 1. The tick that leaves 1 sets the count to 2 and turns it upward again, so the period is 2*modulus-2. The count always stays within 1 to the modulus, provided the modulus is greater than 1.
- R6: In a clock with no tick, the count, the direction and the active modulus hold their values.
- R7: A write (`wr_en` = 1) changes only the shadow register. The active modulus takes the shadow value only on a boundary tick. In up mode the boundary tick is the one that goes from the modulus to 1. In up/down mode it is the one that leaves 1 going upward.
- R8: When a write and a boundary tick fall in the same clock, the active modulus takes the shadow value held before that write. The newly written value waits for the following boundary.
- R9: In up mode the flag is set by the boundary tick. It becomes visible on `flag` in the clock after that tick.
- R10: In up/down mode the flag is set by the tick that makes the count equal to the modulus. It is also set by the boundary tick when `bnd_flag_en` = 1. It becomes visible one clock after that tick.
- R11: The flag remains 1 until `flag_clr` is asserted in a clock with no set event. If a set event and `flag_clr` fall in the same clock, the flag ends up set.
- R12: `active_mod` always shows the active modulus, never the pending shadow value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the shadow modulus |
| wr_data | input | CNT_W | Value for the shadow modulus (must be greater than 1) |
| ud_mode | input | 1 | 0 = up counting, 1 = up/down counting |
| bnd_flag_en | input | 1 | Also set the flag at the boundary in up/down mode |
| ext_sel | input | 1 | 0 = prescaled tick, 1 = pin edge tick |
| edge_sel | input | 2 | Active pin edge selection |
| pre_tick | input | 1 | Prescaled internal tick, one clock wide |
| pin_in | input | 1 | Channel input pin, already synchronous to `clk` |
| flag_clr | input | 1 | Clears the flag |
| count | output | CNT_W | Current count |
| active_mod | output | CNT_W | Active modulus |
| flag | output | 1 | Sticky event flag |

## Verification
Two pairs of events can fall in the same clock.

The first pair is a shadow write and a boundary reload. The bench provokes it by raising `wr_en` in exactly the clock where the count sits on the modulus and a tick is applied. It then judges that `active_mod` takes the old shadow value and takes the new one only one period later.

The second pair is a flag clear and a new set event. The bench drives `flag_clr` continuously or at random while boundaries and modulus matches occur, and checks that the flag resolves to set.

A behavioural reference model runs beside the design and predicts the count, the active modulus and the flag for every clock.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic boundary;
        logic match;
    } cnt_evt_t;

    function automatic logic edge_hit(input edge_sel_e sel, input logic cur, input logic prev);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        return (sel[0] & rise) | (sel[1] & fall);
    endfunction

endpackage

// File: rtl/bmc_tick_sel.sv
module bmc_tick_sel
    import bmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_sel,
    input  logic [1:0] edge_sel,
    input  logic       pre_tick,
    input  logic       pin_in,
    output logic       tick
);

    logic      pin_prev;
    edge_sel_e sel;

    assign sel = edge_sel_e'(edge_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_prev <= 1'b0;
        end else begin
            pin_prev <= pin_in;
        end
    end

    always_comb begin
        if (ext_sel) begin
            tick = edge_hit(sel, pin_in, pin_prev);
        end else begin
            tick = pre_tick;
        end
    end

endmodule

// File: rtl/bmc_core.sv
module bmc_core
    import bmc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int DEF_MOD = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ud_mode,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] active_mod,
    output cnt_evt_t         evt
);

    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO     = CNT_W'(2);
    localparam logic [CNT_W-1:0] RST_MOD = CNT_W'(DEF_MOD);

    logic [CNT_W-1:0] cnt_q,  cnt_d;
    logic [CNT_W-1:0] a1_q,   a1_d;
    logic [CNT_W-1:0] a2_q;
    dir_e             dir_q,  dir_d;

    always_comb begin
        cnt_d        = cnt_q;
        a1_d         = a1_q;
        dir_d        = dir_q;
        evt.boundary = 1'b0;
        evt.match    = 1'b0;
        if (tick) begin
            if (!ud_mode) begin
                dir_d = DIR_UP;
                if (cnt_q == a1_q) begin
                    cnt_d        = ONE;
                    a1_d         = a2_q;
                    evt.boundary = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end else if (dir_q == DIR_UP) begin
                if (cnt_q == a1_q) begin
                    dir_d = DIR_DOWN;
                    cnt_d = cnt_q - ONE;
                end else begin
                    cnt_d     = cnt_q + ONE;
                    evt.match = (cnt_d == a1_q);
                end
            end else begin
                if (cnt_q == ONE) begin
                    dir_d        = DIR_UP;
                    cnt_d        = TWO;
                    a1_d         = a2_q;
                    evt.boundary = 1'b1;
                    evt.match    = (TWO == a2_q);
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= ONE;
            a1_q  <= RST_MOD;
            a2_q  <= RST_MOD;
            dir_q <= DIR_UP;
        end else begin
            cnt_q <= cnt_d;
            a1_q  <= a1_d;
            dir_q <= dir_d;
            if (wr_en) begin
                a2_q <= wr_data;
            end
        end
    end

    assign count      = cnt_q;
    assign active_mod = a1_q;

endmodule

// File: rtl/bmc_flag.sv
module bmc_flag
    import bmc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     ud_mode,
    input  logic     bnd_flag_en,
    input  cnt_evt_t evt,
    input  logic     flag_clr,
    output logic     flag
);

    logic set_evt;
    logic flag_q;

    always_comb begin
        if (ud_mode) begin
            set_evt = tick & (evt.match | (bnd_flag_en & evt.boundary));
        end else begin
            set_evt = tick & evt.boundary;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_evt) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/bmc_channel.sv
module bmc_channel
    import bmc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int DEF_MOD = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ud_mode,
    input  logic             bnd_flag_en,
    input  logic             ext_sel,
    input  logic [1:0]       edge_sel,
    input  logic             pre_tick,
    input  logic             pin_in,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] active_mod,
    output logic             flag
);

    logic     tick_w;
    cnt_evt_t evt_w;

    bmc_tick_sel u_tick (
        .clk      (clk),
        .rst      (rst),
        .ext_sel  (ext_sel),
        .edge_sel (edge_sel),
        .pre_tick (pre_tick),
        .pin_in   (pin_in),
        .tick     (tick_w)
    );

    bmc_core #(
        .CNT_W   (CNT_W),
        .DEF_MOD (DEF_MOD)
    ) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_w),
        .ud_mode    (ud_mode),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .count      (count),
        .active_mod (active_mod),
        .evt        (evt_w)
    );

    bmc_flag u_flag (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick_w),
        .ud_mode     (ud_mode),
        .bnd_flag_en (bnd_flag_en),
        .evt         (evt_w),
        .flag_clr    (flag_clr),
        .flag        (flag)
    );

endmodule

// File: rtl/bmc_checker.sv
module bmc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             ud_mode,
    input logic             flag_clr,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] active_mod,
    input logic             flag
);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (active_mod > CNT_W'(1)) |-> (count >= CNT_W'(1) && count <= active_mod)); // R5

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(count) && $stable(active_mod))); // R6

    AST_RELOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_mod) |-> (count == CNT_W'(1) || count == CNT_W'(2))); // R7

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!ud_mode && tick && count == active_mod) |=> (count == CNT_W'(1))); // R4

    AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(tick)); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag); // R11

endmodule

bind bmc_channel bmc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_w),
    .ud_mode    (ud_mode),
    .flag_clr   (flag_clr),
    .count      (count),
    .active_mod (active_mod),
    .flag       (flag)
);

// File: tb/sim_bmc_channel.sv
module sim_bmc_channel;

    localparam int W   = 16;
    localparam int DEF = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         ud_mode = 1'b0;
    logic         bnd_flag_en = 1'b0;
    logic         ext_sel = 1'b0;
    logic [1:0]   edge_sel = 2'b00;
    logic         pre_tick = 1'b0;
    logic         pin_in = 1'b0;
    logic         flag_clr = 1'b0;
    logic [W-1:0] count;
    logic [W-1:0] active_mod;
    logic         flag;

    int    vectors = 0;
    int    errors  = 0;
    bit    done    = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt, m_a1, m_a2, m_dir, m_pp;
    bit m_flag;

    always #10 clk = ~clk;

    bmc_channel #(.CNT_W(W), .DEF_MOD(DEF)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .ud_mode(ud_mode), .bnd_flag_en(bnd_flag_en), .ext_sel(ext_sel),
        .edge_sel(edge_sel), .pre_tick(pre_tick), .pin_in(pin_in),
        .flag_clr(flag_clr), .count(count), .active_mod(active_mod), .flag(flag)
    );

    always @(posedge clk) begin
        bit tk, setf, rise, fall;
        int old_a2;
        if (rst) begin
            m_cnt = 1; m_a1 = DEF; m_a2 = DEF; m_dir = 0; m_flag = 0; m_pp = 0;
        end else begin
            old_a2 = m_a2;
            rise = pin_in && (m_pp == 0);
            fall = !pin_in && (m_pp == 1);
            tk = ext_sel ? ((edge_sel[0] && rise) || (edge_sel[1] && fall)) : pre_tick;
            setf = 0;
            if (tk) begin
                if (!ud_mode) begin
                    m_dir = 0;
                    if (m_cnt == m_a1) begin m_cnt = 1; m_a1 = old_a2; setf = 1; end
                    else m_cnt++;
                end else if (m_dir == 0) begin
                    if (m_cnt == m_a1) begin m_dir = 1; m_cnt--; end
                    else begin m_cnt++; if (m_cnt == m_a1) setf = 1; end
                end else begin
                    if (m_cnt == 1) begin
                        m_dir = 0; m_cnt = 2; m_a1 = old_a2;
                        if (bnd_flag_en || m_a1 == 2) setf = 1;
                    end else m_cnt--;
                end
            end
            if (setf) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (wr_en) m_a2 = int'(wr_data);
            m_pp = pin_in ? 1 : 0;
        end
    end

    task automatic cyc();
        @(negedge clk);
        vectors++;
        if (int'(count) != m_cnt || int'(active_mod) != m_a1 || flag != m_flag) begin
            errors++;
            $display("FAIL %s count=%0d/%0d active=%0d/%0d flag=%0d/%0d (actual/expected)",
                     cur_req, count, m_cnt, active_mod, m_a1, flag, m_flag);
        end
    endtask

    task automatic run(input int n, input int tick_pct, input int clr_pct);
        for (int i = 0; i < n; i++) begin
            cyc();
            wr_en    = 1'b0;
            pre_tick = (($urandom % 100) < tick_pct);
            flag_clr = (($urandom % 100) < clr_pct);
        end
    endtask

    task automatic write_mod(input int v);
        cyc();
        wr_en    = 1'b1;
        wr_data  = W'(v);
        pre_tick = 1'b0;
        cyc();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 / R12: reset values checked directly
        vectors++;
        if (count != 1 || active_mod != DEF || flag != 0) begin
            errors++;
            $display("FAIL R1 count=%0d active=%0d flag=%0d expected 1/%0d/0",
                     count, active_mod, flag, DEF);
        end

        cur_req = "R4"; run(20, 100, 10);
        cur_req = "R9"; run(20, 100, 30);
        cur_req = "R6"; run(40, 30, 10);

        cur_req = "R7"; write_mod(6);
        cur_req = "R12"; run(20, 100, 20);

        // R8: write exactly on the boundary tick
        cur_req = "R8";
        for (int i = 0; i < 80; i++) begin
            cyc();
            pre_tick = 1'b1;
            flag_clr = ($urandom % 4) == 0;
            wr_en    = (count == active_mod);
            wr_data  = W'(2 + ($urandom % 6));
        end
        wr_en = 1'b0;

        cur_req = "R5"; ud_mode = 1'b1; write_mod(5); run(40, 100, 20);
        cur_req = "R10"; run(30, 60, 15);
        bnd_flag_en = 1'b1; write_mod(2); run(20, 100, 50);
        write_mod(3); run(30, 100, 30);

        // R11: clear held high while set events keep coming
        cur_req = "R11";
        for (int i = 0; i < 30; i++) begin
            cyc();
            pre_tick = 1'b1;
            flag_clr = 1'b1;
        end

        // R2 / R3: pin edges as the tick, prescaled tick toggled as noise
        ud_mode = 1'b0; bnd_flag_en = 1'b0; ext_sel = 1'b1;
        for (int s = 0; s < 4; s++) begin
            cur_req = (s == 0) ? "R2" : "R3";
            edge_sel = 2'(s);
            for (int i = 0; i < 40; i++) begin
                cyc();
                pin_in   = $urandom % 2;
                pre_tick = $urandom % 2;
                flag_clr = ($urandom % 5) == 0;
            end
        end
        ud_mode = 1'b1;
        cur_req = "R3";
        edge_sel = 2'b11;
        for (int i = 0; i < 60; i++) begin
            cyc();
            pin_in   = $urandom % 2;
            pre_tick = $urandom % 2;
            flag_clr = ($urandom % 5) == 0;
        end
        cyc();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL R-all watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule